// File: doc/BRIEF.md
# NOR Flash Sector Erase Sequencer

This block erases one sector of a parallel NOR flash array from the host side. Software or a higher-level controller gives a sector address and a start pulse. The sequencer rounds the address down to the sector boundary. It then checks whether the sector is write-protected by entering the identification mode, reading the protection word and leaving that mode. A protected sector ends the job at once with an error code, and no erase command is sent.

For a sector that is not protected, the block sends the six-write erase command. It then reads the sector base again and again, with a fixed gap between reads, until bit 7 of every device lane reads as one or a timeout runs out. The timeout is set in milliseconds and counted in prescaled ticks. On either outcome it writes the array-mode command so the array can be read again, then pulses `done` together with an error flag and a code.

The flash is reached through a simple one-access-at-a-time bus: a request is held with stable address and data until the device side acknowledges it. Each bus word holds `LANES` parallel devices of `LANE_W` bits. A command byte sits in the low eight bits of every lane, and the upper bits of each lane are zero.

Top module: `nor_sector_eraser`

## Requirements
- R1: After reset `busy`, `done`, `error` and `fl_req` are 0 and `err_code` is 0; while idle no bus request is made.
- R2: On `start` while idle, the base is `sector_addr` with its low log2(`SECTOR_WORDS`) bits cleared. Every access of that job uses the address base OR a 12-bit offset.
- R3: `start` while busy is ignored: the running job keeps its base, and no second job starts once it finishes.
- R4: The protection query is five accesses in this order: write 0xAA at offset 0x555, write 0x55 at 0x2AA, write 0x90 at 0x555, read at 0x002, then write 0xF0 at offset 0. Write data is the command byte in bits [7:0] of each `LANE_W`-bit lane, with the other bits zero.
- R5: If the word read at offset 0x002 is nonzero in any bit, the job ends right after the 0xF0 write with `error`=1 and `err_code`=1. No erase command (0x80) is ever written.
- R6: If the protection word is zero, the erase command follows: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x30@offset 0.
- R7: Completion polling reads offset 0. It ends when bit `k*LANE_W+7` is 1 for every lane k. A read in which only some lanes show that bit set keeps the polling going.
- R8: Each polling read starts at least `POLL_GAP_CYC` cycles after the preceding access was acknowledged.
- R9: A failed poll read ends polling with a timeout once at least `ERASE_TIMEOUT_MS`·`TICK_HZ`/1000 ticks of `CLK_FREQ_HZ`/`TICK_HZ` cycles each have passed since the 0x30 write was acknowledged. The result is then `error`=1 and `err_code`=2.
- R10: After polling ends, by success or by timeout, the block writes 0xF0 at offset 0 and then signals `done`. On success `error`=0 and `err_code`=0.
- R11: `fl_req` with `fl_addr`, `fl_we` and `fl_wdata` is held stable until `fl_ack`, and each acknowledge completes exactly one access.
- R12: `done` is high for one cycle only. `error` and `err_code` keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an erase of the sector holding `sector_addr` |
| sector_addr | input | ADDR_W | Any word address inside the target sector |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| error | output | 1 | Last job failed |
| err_code | output | 2 | 0 success, 1 protected, 2 timeout |
| fl_req | output | 1 | Bus access request |
| fl_we | output | 1 | 1 write, 0 read |
| fl_addr | output | ADDR_W | Bus word address |
| fl_wdata | output | LANES*LANE_W | Write data, command byte per lane |
| fl_rdata | input | LANES*LANE_W | Read data, valid with `fl_ack` |
| fl_ack | input | 1 | Access completed |

## Verification
The bench builds the block with a 16-bit address, two 16-bit lanes and 4096-word sectors. It uses an 8 kHz nominal clock with 1 kHz ticks and a 40 ms timeout, so a tick is 8 cycles and the whole timeout is 320 cycles. That brings a real timeout, with its lower and upper time bounds, within a few hundred cycles. A poll gap of 5 cycles and acknowledge latencies of 0 to 2 cycles exercise both back-to-back accesses and held requests. Unaligned addresses, a lane-1-only protection word and partial-lane status reads cover the alignment, any-bit protection and all-lanes completion rules.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        ERC_NONE      = 2'd0,
        ERC_PROTECTED = 2'd1,
        ERC_TIMEOUT   = 2'd2
    } err_code_e;

    localparam int unsigned STEP_W = 4;
    localparam int unsigned OFF_W  = 12;

    // Job steps, in bus order
    localparam logic [STEP_W-1:0]
        STP_ID_UNLK_A = 4'd0,
        STP_ID_UNLK_B = 4'd1,
        STP_ID_ENTER  = 4'd2,
        STP_ID_READ   = 4'd3,
        STP_ID_EXIT   = 4'd4,
        STP_ER_UNLK_A = 4'd5,
        STP_ER_UNLK_B = 4'd6,
        STP_ER_SETUP  = 4'd7,
        STP_ER_UNLK_C = 4'd8,
        STP_ER_UNLK_D = 4'd9,
        STP_ER_SECTOR = 4'd10,
        STP_POLL      = 4'd11,
        STP_EXIT      = 4'd12;

    localparam logic [OFF_W-1:0]
        OFF_UNLK_A = 12'h555,
        OFF_UNLK_B = 12'h2AA,
        OFF_PROT   = 12'h002,
        OFF_BASE   = 12'h000;

    localparam logic [7:0]
        CMD_UNLK_A = 8'hAA,
        CMD_UNLK_B = 8'h55,
        CMD_IDENT  = 8'h90,
        CMD_ESETUP = 8'h80,
        CMD_SECTOR = 8'h30,
        CMD_ARRAY  = 8'hF0;

    typedef struct packed {
        logic             we;
        logic [OFF_W-1:0] off;
        logic [7:0]       cmd;
    } bus_op_t;

endpackage

// File: rtl/nes_step_rom.sv
module nes_step_rom
    import nor_erase_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    output bus_op_t           op
);

    always_comb begin
        op = '0;
        case (step)
            STP_ID_UNLK_A: op = '{we: 1'b1, off: OFF_UNLK_A, cmd: CMD_UNLK_A};
            STP_ID_UNLK_B: op = '{we: 1'b1, off: OFF_UNLK_B, cmd: CMD_UNLK_B};
            STP_ID_ENTER:  op = '{we: 1'b1, off: OFF_UNLK_A, cmd: CMD_IDENT};
            STP_ID_READ:   op = '{we: 1'b0, off: OFF_PROT,   cmd: 8'h00};
            STP_ID_EXIT:   op = '{we: 1'b1, off: OFF_BASE,   cmd: CMD_ARRAY};
            STP_ER_UNLK_A: op = '{we: 1'b1, off: OFF_UNLK_A, cmd: CMD_UNLK_A};
            STP_ER_UNLK_B: op = '{we: 1'b1, off: OFF_UNLK_B, cmd: CMD_UNLK_B};
            STP_ER_SETUP:  op = '{we: 1'b1, off: OFF_UNLK_A, cmd: CMD_ESETUP};
            STP_ER_UNLK_C: op = '{we: 1'b1, off: OFF_UNLK_A, cmd: CMD_UNLK_A};
            STP_ER_UNLK_D: op = '{we: 1'b1, off: OFF_UNLK_B, cmd: CMD_UNLK_B};
            STP_ER_SECTOR: op = '{we: 1'b1, off: OFF_BASE,   cmd: CMD_SECTOR};
            STP_POLL:      op = '{we: 1'b0, off: OFF_BASE,   cmd: 8'h00};
            STP_EXIT:      op = '{we: 1'b1, off: OFF_BASE,   cmd: CMD_ARRAY};
            default:       op = '0;
        endcase
    end

endmodule

// File: rtl/nes_tick_gen.sv
module nes_tick_gen #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);

    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clear || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/nes_tmo_counter.sv
module nes_tmo_counter #(
    parameter int unsigned LIMIT = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);

    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == TOP);

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick && !expired) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/nor_sector_eraser.sv
module nor_sector_eraser
    import nor_erase_pkg::*;
#(
    parameter int unsigned ADDR_W           = 24,
    parameter int unsigned LANES            = 2,
    parameter int unsigned LANE_W           = 16,
    parameter int unsigned SECTOR_WORDS     = 65536,
    parameter int unsigned CLK_FREQ_HZ      = 125_000_000,
    parameter int unsigned TICK_HZ          = 1000,
    parameter int unsigned ERASE_TIMEOUT_MS = 4000,
    parameter int unsigned POLL_GAP_CYC     = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         sector_addr,
    output logic                      busy,
    output logic                      done,
    output logic                      error,
    output logic [1:0]                err_code,
    output logic                      fl_req,
    output logic                      fl_we,
    output logic [ADDR_W-1:0]         fl_addr,
    output logic [LANES*LANE_W-1:0]   fl_wdata,
    input  logic [LANES*LANE_W-1:0]   fl_rdata,
    input  logic                      fl_ack
);

    localparam int unsigned TICK_DIV  = CLK_FREQ_HZ / TICK_HZ;
    localparam int unsigned TMO_TICKS = ERASE_TIMEOUT_MS * TICK_HZ / 1000;
    localparam int unsigned GAP_W     = $clog2(POLL_GAP_CYC + 1);
    localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'(SECTOR_WORDS - 1);
    localparam logic [GAP_W-1:0]  GAP_LOAD  = GAP_W'(POLL_GAP_CYC - 1);

    typedef struct packed {
        state_e              st;
        logic [STEP_W-1:0]   step;
        logic [ADDR_W-1:0]   base;
        logic                prot;
        logic                tmo;
        logic [GAP_W-1:0]    gap;
        logic                done;
        logic                err;
        logic [1:0]          code;
    } regs_t;

    regs_t   d, q;
    bus_op_t op;
    logic    tmr_clear;
    logic    tick;
    logic    tmo_expired;
    logic [LANES-1:0] lane_b7;
    logic    all_ready;

    nes_step_rom u_rom (
        .step (q.step),
        .op   (op)
    );

    nes_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .tick  (tick)
    );

    nes_tmo_counter #(.LIMIT(TMO_TICKS)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .tick    (tick),
        .expired (tmo_expired)
    );

    // Per-lane command replication and status bit extraction
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign fl_wdata[k*LANE_W +: LANE_W] = LANE_W'(op.cmd);
        assign lane_b7[k] = fl_rdata[k*LANE_W + 7];
    end

    assign all_ready = &lane_b7;

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign error    = q.err;
    assign err_code = q.code;
    assign fl_req   = (q.st == ST_ISSUE);
    assign fl_we    = op.we;
    assign fl_addr  = q.base | ADDR_W'(op.off);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        tmr_clear = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_ISSUE;
                    d.step = STP_ID_UNLK_A;
                    d.base = sector_addr & ~SECT_MASK;
                    d.prot = 1'b0;
                    d.tmo  = 1'b0;
                    d.err  = 1'b0;
                    d.code = ERC_NONE;
                end
            end
            ST_ISSUE: begin
                if (fl_ack) begin
                    d.step = q.step + STEP_W'(1);
                    case (q.step)
                        STP_ID_READ: begin
                            d.prot = |fl_rdata;
                        end
                        STP_ID_EXIT: begin
                            if (q.prot) begin
                                d.st   = ST_IDLE;
                                d.done = 1'b1;
                                d.err  = 1'b1;
                                d.code = ERC_PROTECTED;
                            end
                        end
                        STP_ER_SECTOR: begin
                            tmr_clear = 1'b1;
                            d.st      = ST_GAP;
                            d.gap     = GAP_LOAD;
                        end
                        STP_POLL: begin
                            if (!all_ready) begin
                                if (tmo_expired) begin
                                    d.tmo = 1'b1;
                                end else begin
                                    d.step = q.step;
                                    d.st   = ST_GAP;
                                    d.gap  = GAP_LOAD;
                                end
                            end
                        end
                        STP_EXIT: begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                            d.err  = q.tmo;
                            d.code = q.tmo ? ERC_TIMEOUT : ERC_NONE;
                        end
                        default: ;
                    endcase
                end
            end
            ST_GAP: begin
                if (q.gap == '0) begin
                    d.st = ST_ISSUE;
                end else begin
                    d.gap = q.gap - GAP_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.code <= ERC_NONE;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nor_sector_eraser_chk.sv
module nor_sector_eraser_chk #(
    parameter int unsigned ADDR_W       = 24,
    parameter int unsigned LANES        = 2,
    parameter int unsigned LANE_W       = 16,
    parameter int unsigned SECTOR_WORDS = 65536
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic [ADDR_W-1:0]       sector_addr,
    input logic                    busy,
    input logic                    done,
    input logic                    error,
    input logic [1:0]              err_code,
    input logic                    fl_req,
    input logic                    fl_we,
    input logic [ADDR_W-1:0]       fl_addr,
    input logic [LANES*LANE_W-1:0] fl_wdata,
    input logic                    fl_ack
);

    localparam logic [ADDR_W-1:0] MASK = ADDR_W'(SECTOR_WORDS - 1);

    logic [ADDR_W-1:0] base_q;
    logic              erase_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q       <= '0;
            erase_seen_q <= 1'b0;
        end else if (start && !busy) begin
            base_q       <= sector_addr & ~MASK;
            erase_seen_q <= 1'b0;
        end else if (fl_req && fl_ack && fl_we && fl_wdata[7:0] == 8'h80) begin
            erase_seen_q <= 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fl_req);

    p_in_sector_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> ((fl_addr & ~MASK) == base_q));

    p_no_erase_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == 2'd1) |-> !erase_seen_q);

    p_flag_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (error == (err_code != 2'd0)));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr) && $stable(fl_we)
                                 && $stable(fl_wdata)));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind nor_sector_eraser nor_sector_eraser_chk #(
    .ADDR_W       (ADDR_W),
    .LANES        (LANES),
    .LANE_W       (LANE_W),
    .SECTOR_WORDS (SECTOR_WORDS)
) u_chk (.*);

// File: tb/nor_sector_eraser_tb.sv
module nor_sector_eraser_tb;

    localparam int ADDR_W   = 16;
    localparam int LANES    = 2;
    localparam int LANE_W   = 16;
    localparam int SECT     = 4096;
    localparam int CLK_HZ   = 8000;
    localparam int TICK_HZ  = 1000;
    localparam int TMO_MS   = 40;
    localparam int GAP      = 5;
    localparam int TOTAL    = (CLK_HZ / TICK_HZ) * (TMO_MS * TICK_HZ / 1000);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] sector_addr = '0;
    logic              busy, done, error;
    logic [1:0]        err_code;
    logic              fl_req, fl_we;
    logic [ADDR_W-1:0] fl_addr;
    logic [31:0]       fl_wdata;
    logic [31:0]       fl_rdata = '0;
    logic              fl_ack = 1'b0;

    always #4 clk = ~clk;

    nor_sector_eraser #(
        .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .SECTOR_WORDS(SECT),
        .CLK_FREQ_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .ERASE_TIMEOUT_MS(TMO_MS),
        .POLL_GAP_CYC(GAP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sector_addr(sector_addr),
        .busy(busy), .done(done), .error(error), .err_code(err_code),
        .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .fl_ack(fl_ack)
    );

    int tests = 0;
    int fails = 0;
    longint cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        bit          we;
        logic [15:0] a;
        logic [31:0] d;
        string       req;
    } op_t;

    op_t         expq[$];
    logic [15:0] base_exp;
    logic [31:0] prot_val;
    int          polls_needed;
    bit          partial;
    int          lat;
    bit          erase_sent;
    int          polls_seen;
    longint      erase_ack_cyc, exit_cyc, last_ack_cyc, req_start;
    bit          in_req;
    int          wait_cnt;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    bit          held_ok;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] splat(input logic [7:0] b);
        return {8'h00, b, 8'h00, b};
    endfunction

    function automatic op_t mk(input bit we, input logic [11:0] off,
                               input logic [7:0] c, input string r);
        op_t o;
        o.we = we; o.a = base_exp | {4'h0, off}; o.d = splat(c); o.req = r;
        return o;
    endfunction

    // Device-side model: handles one acknowledged access
    task automatic serve();
        op_t o;
        chk(held_ok, "R11", "request held stable", {48'h0, fl_addr}, {48'h0, req_addr});
        if (!fl_we && erase_sent && fl_addr == base_exp) begin
            polls_seen++;
            chk(req_start - last_ack_cyc >= GAP, "R8", "poll spacing",
                req_start - last_ack_cyc, GAP);
            if (polls_needed >= 0 && polls_seen > polls_needed)
                fl_rdata = 32'h0080_0080;
            else
                fl_rdata = partial ? 32'h0000_0080 : 32'h0000_0000;
        end else if (expq.size() == 0) begin
            chk(1'b0, "R5", "unexpected access", {48'h0, fl_addr}, 64'h0);
        end else begin
            o = expq.pop_front();
            chk(fl_we == o.we && fl_addr == o.a && (!o.we || fl_wdata == o.d), o.req,
                "access", {15'h0, fl_we, fl_addr, fl_wdata}, {15'h0, o.we, o.a, o.d});
            if (!o.we) fl_rdata = prot_val;
            if (o.we && o.d == splat(8'h30)) begin
                erase_sent = 1'b1;
                erase_ack_cyc = cyc;
            end
            if (o.we && erase_sent && o.d == splat(8'hF0)) exit_cyc = cyc;
        end
        last_ack_cyc = cyc;
    endtask

    always @(negedge clk) begin
        fl_ack = 1'b0;
        if (rst_n && fl_req) begin
            if (!in_req) begin
                in_req = 1'b1; wait_cnt = 0; req_start = cyc;
                req_addr = fl_addr; req_wdata = fl_wdata; held_ok = 1'b1;
            end else if (fl_addr != req_addr || fl_wdata != req_wdata) begin
                held_ok = 1'b0;
            end
            if (wait_cnt >= lat) begin
                fl_ack = 1'b1;
                in_req = 1'b0;
                serve();
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic run_job(input logic [15:0] addr, input logic [31:0] pv, input int pn,
                           input bit part, input int latency, input bit poke);
        bit seen = 1'b0;
        bit exp_err;
        logic [1:0] exp_code;
        bit stray = 1'b0;
        base_exp = addr & ~16'(SECT - 1);
        prot_val = pv; polls_needed = pn; partial = part; lat = latency;
        erase_sent = 1'b0; polls_seen = 0; exit_cyc = 0; expq.delete();
        expq.push_back(mk(1, 12'h555, 8'hAA, "R4"));
        expq.push_back(mk(1, 12'h2AA, 8'h55, "R4"));
        expq.push_back(mk(1, 12'h555, 8'h90, "R4"));
        expq.push_back(mk(0, 12'h002, 8'h00, "R4"));
        expq.push_back(mk(1, 12'h000, 8'hF0, "R4"));
        if (pv == 0) begin
            expq.push_back(mk(1, 12'h555, 8'hAA, "R6"));
            expq.push_back(mk(1, 12'h2AA, 8'h55, "R6"));
            expq.push_back(mk(1, 12'h555, 8'h80, "R6"));
            expq.push_back(mk(1, 12'h555, 8'hAA, "R6"));
            expq.push_back(mk(1, 12'h2AA, 8'h55, "R6"));
            expq.push_back(mk(1, 12'h000, 8'h30, "R6"));
            expq.push_back(mk(1, 12'h000, 8'hF0, "R10"));
        end
        exp_err  = (pv != 0) || (pn < 0);
        exp_code = (pv != 0) ? 2'd1 : ((pn < 0) ? 2'd2 : 2'd0);
        @(negedge clk); sector_addr = addr; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            sector_addr = 16'h7000; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        for (int n = 0; n < 5000 && !seen; n++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(seen, "R10", "done seen", {63'h0, seen}, 64'h1);
        chk(error == exp_err && err_code == exp_code, pv != 0 ? "R5" : (pn < 0 ? "R9" : "R10"),
            "result", {61'h0, error, err_code}, {61'h0, exp_err, exp_code});
        chk(expq.size() == 0, "R5", "accesses left", expq.size(), 0);
        if (pv == 0 && pn >= 0)
            chk(polls_seen == pn + 1, "R7", "poll count", polls_seen, pn + 1);
        if (pn < 0 && pv == 0) begin
            chk(exit_cyc - erase_ack_cyc >= TOTAL, "R9", "timeout not early",
                exit_cyc - erase_ack_cyc, TOTAL);
            chk(exit_cyc - erase_ack_cyc <= TOTAL + GAP + 20, "R9", "timeout not late",
                exit_cyc - erase_ack_cyc, TOTAL + GAP + 20);
        end
        @(negedge clk);
        chk(!done && error == exp_err && err_code == exp_code, "R12", "pulse and hold",
            {60'h0, done, error, err_code}, {61'h0, exp_err, exp_code});
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (fl_req || busy) stray = 1'b1;
        end
        chk(!stray, poke ? "R3" : "R1", "quiet after job", {63'h0, stray}, 64'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy && !done && !error && err_code == 0 && !fl_req, "R1", "reset state",
            {59'h0, busy, done, error, err_code, fl_req}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !fl_req, "R1", "idle after reset", {62'h0, busy, fl_req}, 64'h0);
        // R2 unaligned address, ready after three busy reads
        run_job(16'h3ABC, 32'h0, 3, 1'b0, 0, 1'b0);
        // R5 protection flagged in upper lane only
        run_job(16'h5004, 32'h0001_0000, 0, 1'b0, 1, 1'b0);
        // R7 partial-lane status, R3 start while busy, R11 held requests
        run_job(16'h2FFF, 32'h0, 2, 1'b1, 2, 1'b1);
        // R9 never ready
        run_job(16'h1000, 32'h0, -1, 1'b0, 1, 1'b0);
        // R12 flags cleared by a new successful job
        run_job(16'hF123, 32'h0, 0, 1'b0, 0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule